// File: doc/BRIEF.md
# Banked Indexed Register Port

This block is the host-facing byte register front end of a video output device. The host sees four byte-wide ports, addressed by a 2-bit port address. An external bank bit decides what those four ports mean. With the bank bit low, the ports serve the colour palette: a pixel mask, a palette read pointer, a palette write pointer and a palette data port. Palette data writes leave the block as a one-cycle strobe. With the bank bit high, the same ports give access to a 16-bit indexed register space. The host sets the index low and high bytes, sets an index control byte, and moves data through a single data port.

The indexed space holds two regions. A 256-byte control register file sits at indices whose high byte is zero. A 1024-byte cursor image array sits at a higher base. When auto-increment is enabled in the index control byte, the index advances after every data access. This lets the host stream a whole cursor image with one index setup. All reads return through a registered read bus, which is valid one cycle after the read strobe. The meaning of the control registers and the palette lookup itself are handled elsewhere.

Top module: `banked_index_port`

## Requirements
- R1: After reset, the pixel mask is 0xFF, the index is 0x0000, the index control byte is 0x00, `rd_valid` is low and `pal_wr_en` is low.
- R2: With `bank_sel`=0, writes to port 0 set the pixel mask, writes to port 1 set the palette read pointer (`pal_rd_addr`) and writes to port 2 set the palette write pointer. Reads of ports 0, 1 and 2 return these values.
- R3: With `bank_sel`=0, a write to port 3 raises `pal_wr_en` for exactly one cycle, starting the cycle after the write, with `pal_wr_data` set to the written byte and `pal_wr_addr` set to the palette write pointer. A read of port 3 returns `pal_rd_data`.
- R4: With `bank_sel`=1, port 2 is the index low byte, port 3 is the index high byte, port 1 is the index control byte and port 0 is the indexed data port. Reads of ports 1, 2 and 3 return their stored bytes.
- R5: `rd_data` carries the read result and `rd_valid` is high in the cycle after a cycle in which `rd_en` is high and `wr_en` is low. `rd_valid` is low in every other cycle. If `wr_en` and `rd_en` are both high, the write is performed and the read is dropped.
- R6: Indices 0x0000 to 0x00FF address 256 independent byte registers. Each can be written and read back through the data port.
- R7: When bit 0 of the index control byte is 1, the index increases by one after every read or write of the data port. When that bit is 0, data accesses leave the index unchanged.
- R8: Auto-increment wraps the index from 0xFFFF to 0x0000.
- R9: Indices 0x0100 to 0x04FF address a 1024-byte cursor array. The array can be loaded by setting the index to 0x0100 and writing 1024 bytes with auto-increment on, which leaves the index at 0x0500.
- R10: Data writes to indices 0x0500 to 0xFFFF change no stored byte. Data reads of those indices return 0x00.
- R11: Accesses with `bank_sel`=0 do not change the index or the index control byte. Accesses with `bank_sel`=1 do not pulse `pal_wr_en` and do not change the pixel mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_sel | input | 1 | Bank select: 0 = palette ports, 1 = indexed ports |
| addr | input | 2 | Host port address |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| wr_data | input | 8 | Host write byte |
| rd_data | output | 8 | Registered read byte |
| rd_valid | output | 1 | High for the cycle that follows an accepted read |
| pixel_mask | output | 8 | Current pixel mask |
| pal_wr_en | output | 1 | One-cycle palette data write strobe |
| pal_wr_addr | output | 8 | Palette entry targeted by the write strobe |
| pal_wr_data | output | 8 | Palette byte carried by the write strobe |
| pal_rd_addr | output | 8 | Palette read pointer |
| pal_rd_data | input | 8 | Palette byte returned for a palette data read |

## Verification
The bound checker watches every cycle for the following properties: the read-valid timing, the palette strobe and its data, the index step or hold after each data access, and the isolation of the index from palette-bank traffic. The index step check is written modulo 2^16, so it also covers the wrap. The scenarios must show the things that depend on storage contents. These are that every one of the 256 control registers and 1024 cursor bytes keeps its own value, that writes beyond the cursor array alter nothing, that such reads return zero, and that the reset values read back correctly through the host ports.

// File: rtl/bip_pkg.sv
package bip_pkg;

    localparam int BYTE_W = 8;
    localparam int IDX_W  = 16;
    localparam int PORT_AW = 2;

    typedef enum logic [3:0] {
        P_NONE,
        P_PIXMASK,
        P_RDPTR,
        P_WRPTR,
        P_PALDATA,
        P_IDXDATA,
        P_IDXCTRL,
        P_IDXLO,
        P_IDXHI
    } port_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        port_e             port;
        logic [BYTE_W-1:0] data;
    } host_req_t;

    // Map a bank bit and a port address onto a named port.
    function automatic port_e port_of(input logic bank, input logic [PORT_AW-1:0] a);
        port_e p;
        if (!bank) begin
            case (a)
                2'd0:    p = P_PIXMASK;
                2'd1:    p = P_RDPTR;
                2'd2:    p = P_WRPTR;
                default: p = P_PALDATA;
            endcase
        end else begin
            case (a)
                2'd0:    p = P_IDXDATA;
                2'd1:    p = P_IDXCTRL;
                2'd2:    p = P_IDXLO;
                default: p = P_IDXHI;
            endcase
        end
        return p;
    endfunction

endpackage

// File: rtl/bip_decode.sv
module bip_decode
    import bip_pkg::*;
(
    input  logic               bank_sel,
    input  logic [PORT_AW-1:0] addr,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [BYTE_W-1:0]  wr_data,
    output host_req_t          req
);
    always_comb begin
        req.wr   = wr_en;
        req.rd   = rd_en & ~wr_en;
        req.port = (wr_en | rd_en) ? port_of(bank_sel, addr) : P_NONE;
        req.data = wr_data;
    end
endmodule

// File: rtl/bip_index.sv
module bip_index
    import bip_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  host_req_t         req,
    output logic [IDX_W-1:0]  idx,
    output logic [BYTE_W-1:0] ctrl
);
    localparam int HI_W = IDX_W - BYTE_W;

    logic data_hit;
    assign data_hit = (req.wr | req.rd) && (req.port == P_IDXDATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx  <= '0;
            ctrl <= '0;
        end else if (req.wr && req.port == P_IDXLO) begin
            idx[BYTE_W-1:0] <= req.data;
        end else if (req.wr && req.port == P_IDXHI) begin
            idx[IDX_W-1:BYTE_W] <= req.data[HI_W-1:0];
        end else if (req.wr && req.port == P_IDXCTRL) begin
            ctrl <= req.data;
        end else if (data_hit && ctrl[0]) begin
            idx <= idx + 1'b1;
        end
    end
endmodule

// File: rtl/bip_store.sv
module bip_store
    import bip_pkg::*;
#(
    parameter int REG_N    = 256,
    parameter int CUR_BASE = 256,
    parameter int CUR_N    = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  idx,
    input  logic              we,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata
);
    localparam int REG_AW = $clog2(REG_N);
    localparam int CUR_AW = $clog2(CUR_N);
    localparam logic [IDX_W-1:0] REG_END = IDX_W'(REG_N);
    localparam logic [IDX_W-1:0] CUR_LO  = IDX_W'(CUR_BASE);
    localparam logic [IDX_W-1:0] CUR_END = IDX_W'(CUR_BASE + CUR_N);

    logic [BYTE_W-1:0] regs [REG_N];
    logic [BYTE_W-1:0] cur  [CUR_N];

    logic              reg_hit, cur_hit;
    logic [REG_AW-1:0] reg_off;
    logic [CUR_AW-1:0] cur_off;
    logic [IDX_W-1:0]  cur_rel;

    assign reg_hit = idx < REG_END;
    assign cur_hit = (idx >= CUR_LO) && (idx < CUR_END);
    assign reg_off = idx[REG_AW-1:0];
    assign cur_rel = idx - CUR_LO;
    assign cur_off = cur_rel[CUR_AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < REG_N; i++) regs[i] <= '0;
        end else if (we && reg_hit) begin
            regs[reg_off] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (we && cur_hit) cur[cur_off] <= wdata;
    end

    always_comb begin
        if (reg_hit)      rdata = regs[reg_off];
        else if (cur_hit) rdata = cur[cur_off];
        else              rdata = '0;
    end
endmodule

// File: rtl/banked_index_port.sv
module banked_index_port
    import bip_pkg::*;
#(
    parameter int REG_N    = 256,
    parameter int CUR_BASE = 256,
    parameter int CUR_N    = 1024
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bank_sel,
    input  logic [1:0]  addr,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [7:0]  wr_data,
    output logic [7:0]  rd_data,
    output logic        rd_valid,
    output logic [7:0]  pixel_mask,
    output logic        pal_wr_en,
    output logic [7:0]  pal_wr_addr,
    output logic [7:0]  pal_wr_data,
    output logic [7:0]  pal_rd_addr,
    input  logic [7:0]  pal_rd_data
);
    localparam int HI_W = IDX_W - BYTE_W;

    host_req_t         req;
    logic [IDX_W-1:0]  idx_q;
    logic [BYTE_W-1:0] ctrl_q;
    logic [BYTE_W-1:0] store_rd;
    logic [BYTE_W-1:0] wr_ptr;
    logic [BYTE_W-1:0] rd_mux;

    bip_decode u_dec (
        .bank_sel (bank_sel),
        .addr     (addr),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .wr_data  (wr_data),
        .req      (req)
    );

    bip_index u_idx (
        .clk  (clk),
        .rst  (rst),
        .req  (req),
        .idx  (idx_q),
        .ctrl (ctrl_q)
    );

    bip_store #(
        .REG_N    (REG_N),
        .CUR_BASE (CUR_BASE),
        .CUR_N    (CUR_N)
    ) u_store (
        .clk   (clk),
        .rst   (rst),
        .idx   (idx_q),
        .we    (req.wr && req.port == P_IDXDATA),
        .wdata (req.data),
        .rdata (store_rd)
    );

    // Palette-bank state and write strobe.
    always_ff @(posedge clk) begin
        if (rst) begin
            pixel_mask  <= 8'hFF;
            pal_rd_addr <= '0;
            wr_ptr      <= '0;
            pal_wr_en   <= 1'b0;
            pal_wr_addr <= '0;
            pal_wr_data <= '0;
        end else begin
            pal_wr_en <= 1'b0;
            if (req.wr) begin
                case (req.port)
                    P_PIXMASK: pixel_mask  <= req.data;
                    P_RDPTR:   pal_rd_addr <= req.data;
                    P_WRPTR:   wr_ptr      <= req.data;
                    P_PALDATA: begin
                        pal_wr_en   <= 1'b1;
                        pal_wr_addr <= wr_ptr;
                        pal_wr_data <= req.data;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (req.port)
            P_PIXMASK: rd_mux = pixel_mask;
            P_RDPTR:   rd_mux = pal_rd_addr;
            P_WRPTR:   rd_mux = wr_ptr;
            P_PALDATA: rd_mux = pal_rd_data;
            P_IDXDATA: rd_mux = store_rd;
            P_IDXCTRL: rd_mux = ctrl_q;
            P_IDXLO:   rd_mux = idx_q[BYTE_W-1:0];
            P_IDXHI:   rd_mux = BYTE_W'(idx_q[IDX_W-1:BYTE_W]);
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= req.rd;
            if (req.rd) rd_data <= rd_mux;
        end
    end
endmodule

// File: rtl/bip_checker.sv
module bip_checker (
    input logic        clk,
    input logic        rst,
    input logic        bank_sel,
    input logic [1:0]  addr,
    input logic        wr_en,
    input logic        rd_en,
    input logic [7:0]  wr_data,
    input logic        rd_valid,
    input logic        pal_wr_en,
    input logic [7:0]  pal_wr_data,
    input logic [15:0] idx,
    input logic [7:0]  ctrl
);
    logic pal_wr_req, data_acc, rd_req;
    assign pal_wr_req = wr_en && !bank_sel && addr == 2'd3;
    assign data_acc   = (wr_en || rd_en) && bank_sel && addr == 2'd0;
    assign rd_req     = rd_en && !wr_en;

    a_r5_valid_after_read: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> rd_valid);
    a_r5_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> !rd_valid);
    a_r3_pal_strobe: assert property (@(posedge clk) disable iff (rst)
        pal_wr_req |=> (pal_wr_en && pal_wr_data == $past(wr_data)));
    a_r11_pal_quiet: assert property (@(posedge clk) disable iff (rst)
        !pal_wr_req |=> !pal_wr_en);
    // R7 and R8: a 16-bit step covers the wrap.
    a_r7_index_step: assert property (@(posedge clk) disable iff (rst)
        (data_acc && ctrl[0]) |=> idx == $past(idx) + 16'd1);
    a_r7_index_hold: assert property (@(posedge clk) disable iff (rst)
        (data_acc && !ctrl[0]) |=> $stable(idx));
    a_r11_index_isolated: assert property (@(posedge clk) disable iff (rst)
        (!bank_sel && (wr_en || rd_en)) |=> ($stable(idx) && $stable(ctrl)));
endmodule

bind banked_index_port bip_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .bank_sel    (bank_sel),
    .addr        (addr),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .wr_data     (wr_data),
    .rd_valid    (rd_valid),
    .pal_wr_en   (pal_wr_en),
    .pal_wr_data (pal_wr_data),
    .idx         (idx_q),
    .ctrl        (ctrl_q)
);

// File: tb/sim_banked_index_port.sv
`timescale 1ns/1ps
module sim_banked_index_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bank_sel = 1'b0;
    logic [1:0] addr = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       rd_valid;
    logic [7:0] pixel_mask;
    logic       pal_wr_en;
    logic [7:0] pal_wr_addr, pal_wr_data, pal_rd_addr;
    logic [7:0] pal_rd_data = 8'hC3;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    banked_index_port u0 (
        .clk(clk), .rst(rst), .bank_sel(bank_sel), .addr(addr),
        .wr_en(wr_en), .rd_en(rd_en), .wr_data(wr_data),
        .rd_data(rd_data), .rd_valid(rd_valid), .pixel_mask(pixel_mask),
        .pal_wr_en(pal_wr_en), .pal_wr_addr(pal_wr_addr),
        .pal_wr_data(pal_wr_data), .pal_rd_addr(pal_rd_addr),
        .pal_rd_data(pal_rd_data)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic b, input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bank_sel = b; addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic b, input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bank_sel = b; addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
        if (!rd_valid) begin
            total++; bad++;
            $display("FAIL R5 actual=rd_valid 0 expected=rd_valid 1");
        end
    endtask

    task automatic set_idx(input logic [15:0] v);
        wr(1'b1, 2'd2, v[7:0]);
        wr(1'b1, 2'd3, v[15:8]);
    endtask

    task automatic chk_idx(input string req, input logic [15:0] exp);
        logic [7:0] lo, hi;
        rd(1'b1, 2'd2, lo);
        rd(1'b1, 2'd3, hi);
        chk(req, {hi, lo}, exp);
    endtask

    function automatic logic [7:0] fr(input int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    function automatic logic [7:0] fc(input int i);
        return 8'((i * 13 + (i >> 8) + 5) & 255);
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 pixel_mask", 16'(pixel_mask), 16'h00FF);
        chk("R1 rd_valid", 16'(rd_valid), 16'h0000);
        chk("R1 pal_wr_en", 16'(pal_wr_en), 16'h0000);
        chk_idx("R1 index", 16'h0000);
        rd(1'b1, 2'd1, d); chk("R1 ctrl", 16'(d), 16'h0000);
        @(negedge clk);
        chk("R5 idle valid low", 16'(rd_valid), 16'h0000);

        // R2 palette bank registers
        wr(1'b0, 2'd0, 8'h5A);
        wr(1'b0, 2'd1, 8'h33);
        wr(1'b0, 2'd2, 8'h44);
        chk("R2 pixel_mask", 16'(pixel_mask), 16'h005A);
        chk("R2 pal_rd_addr", 16'(pal_rd_addr), 16'h0033);
        rd(1'b0, 2'd0, d); chk("R2 read mask", 16'(d), 16'h005A);
        rd(1'b0, 2'd1, d); chk("R2 read rdptr", 16'(d), 16'h0033);
        rd(1'b0, 2'd2, d); chk("R2 read wrptr", 16'(d), 16'h0044);

        // R3 palette data
        wr(1'b0, 2'd3, 8'h99);
        chk("R3 strobe", 16'(pal_wr_en), 16'h0001);
        chk("R3 addr", 16'(pal_wr_addr), 16'h0044);
        chk("R3 data", 16'(pal_wr_data), 16'h0099);
        @(negedge clk);
        chk("R3 single cycle", 16'(pal_wr_en), 16'h0000);
        rd(1'b0, 2'd3, d); chk("R3 read data", 16'(d), 16'h00C3);

        // R11 isolation of both banks
        chk_idx("R11 index after palette traffic", 16'h0000);
        wr(1'b1, 2'd3, 8'h00);
        chk("R11 no strobe from bank1", 16'(pal_wr_en), 16'h0000);
        chk("R11 mask untouched", 16'(pixel_mask), 16'h005A);

        // R4 control byte
        wr(1'b1, 2'd1, 8'hA5);
        rd(1'b1, 2'd1, d); chk("R4 ctrl readback", 16'(d), 16'h00A5);
        set_idx(16'h1234);
        chk_idx("R4 index bytes", 16'h1234);

        // R6 and R7: full register file sweep with auto-increment
        wr(1'b1, 2'd1, 8'h01);
        set_idx(16'h0000);
        for (int i = 0; i < 256; i++) wr(1'b1, 2'd0, fr(i));
        chk_idx("R7 index after 256 writes", 16'h0100);
        set_idx(16'h0000);
        for (int i = 0; i < 256; i++) begin
            rd(1'b1, 2'd0, d);
            chk("R6 register file", 16'(d), 16'(fr(i)));
        end
        chk_idx("R7 index after 256 reads", 16'h0100);

        // R9 cursor array streaming load
        set_idx(16'h0100);
        for (int i = 0; i < 1024; i++) wr(1'b1, 2'd0, fc(i));
        chk_idx("R9 index after load", 16'h0500);
        set_idx(16'h0100);
        for (int i = 0; i < 1024; i++) begin
            rd(1'b1, 2'd0, d);
            chk("R9 cursor byte", 16'(d), 16'(fc(i)));
        end
        set_idx(16'h00FF);
        rd(1'b1, 2'd0, d); chk("R9 regfile top kept", 16'(d), 16'(fr(255)));

        // R7 auto-increment disabled
        wr(1'b1, 2'd1, 8'h00);
        set_idx(16'h0010);
        wr(1'b1, 2'd0, 8'h77);
        wr(1'b1, 2'd0, 8'h78);
        chk_idx("R7 hold after writes", 16'h0010);
        rd(1'b1, 2'd0, d); chk("R7 last write wins", 16'(d), 16'h0078);
        chk_idx("R7 hold after read", 16'h0010);

        // R10 unimplemented indices
        set_idx(16'h0500);
        wr(1'b1, 2'd0, 8'hAA);
        rd(1'b1, 2'd0, d); chk("R10 read 0x0500", 16'(d), 16'h0000);
        set_idx(16'h8000);
        wr(1'b1, 2'd0, 8'hAA);
        rd(1'b1, 2'd0, d); chk("R10 read 0x8000", 16'(d), 16'h0000);
        set_idx(16'h0100);
        rd(1'b1, 2'd0, d); chk("R10 cursor not aliased", 16'(d), 16'(fc(0)));
        set_idx(16'h0000);
        rd(1'b1, 2'd0, d); chk("R10 regfile not aliased", 16'(d), 16'(fr(0)));

        // R8 wrap
        wr(1'b1, 2'd1, 8'h01);
        set_idx(16'hFFFF);
        wr(1'b1, 2'd0, 8'h12);
        chk_idx("R8 wrap after write", 16'h0000);
        set_idx(16'hFFFF);
        rd(1'b1, 2'd0, d); chk("R8 read at top", 16'(d), 16'h0000);
        chk_idx("R8 wrap after read", 16'h0000);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule